// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine sits beside the data path of a NAND flash controller and computes a Hamming code over every 512-byte block of a page while the bytes stream past, one byte per clock. A page holds up to four blocks. Each block gets its own 24-bit code, which can correct any single flipped bit and detect any two flipped bits in that block.

In write mode the engine emits each block's code as soon as the block's last byte has passed, so the controller can store the codes in the spare area after the page data. In read mode it keeps the recomputed codes. The controller then feeds the stored codes back from the spare area, in block order. For each block the engine reports one of four results: clean, a single data bit error with its location, a damaged stored code, or an uncorrectable error. The results stay in place until the next page starts. Repairing the data buffer and driving the flash bus belong to other logic.

A page starts only when the start strobe comes with a block-aligned address offset. A misaligned start does nothing.

Top module: `hecc_page_engine`

## Requirements
- R1: After reset, `code_valid_o` is 0 and `stat_o`, `loc_o` and `chk_done_o` are all zero.
- R2: In write mode, `code_valid_o` is high for exactly one cycle, in the cycle after the 512th accepted byte of each block. At the same time `code_blk_o` holds the block number (0 to 3, in stream order).
- R3: The code has four parts. Bits [2:0] are odd column parities: bit k is the XOR of every data bit whose bit position has bit k set. Bits [11:3] are odd line parities: bit k is the XOR of the parities of every byte whose in-block index has bit k set. Bits [14:12] and [23:15] are the matching even parities, taken where that index bit is clear.
- R4: A start strobe whose offset `start_ofs_i` is not zero does not start a page, and the bytes that follow it produce no code.
- R5: A byte counts only when `din_valid_i` is high while a page is in its data phase. Bytes that arrive after the fourth block of a page are ignored.
- R6: In read mode, stored codes are accepted one per `chk_valid_i` cycle once all four blocks have streamed. The cycle after a code is accepted, `chk_done_o[k]` is set for that block. A block whose syndrome (stored XOR computed) is zero reports status 2'b00 with location 0.
- R7: A syndrome whose two 12-bit halves are exact complements reports status 2'b01. Its location is then the low half of the syndrome: bits [11:3] give the byte index and bits [2:0] the bit index.
- R8: A syndrome with exactly one bit set reports status 2'b10 (the stored code is damaged), with location 0.
- R9: Any other nonzero syndrome reports status 2'b11 (uncorrectable), with location 0.
- R10: Results hold until an aligned start. The cycle after that start, all status, location and done bits are zero.
- R11: Read mode emits no code pulses. Write mode ignores `chk_valid_i`.
- R12: Stored codes apply to blocks 0, 1, 2 and 3 in turn. Any further stored code before the next start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-page strobe |
| start_ofs_i | input | 9 | Address bits below the block size for the starting access |
| wr_mode_i | input | 1 | 1 = write page, 0 = read page; sampled with the start strobe |
| din_valid_i | input | 1 | Byte qualifier |
| din_i | input | 8 | Page data byte |
| chk_valid_i | input | 1 | Stored code qualifier (read mode) |
| chk_code_i | input | 24 | Stored code read back from the spare area |
| code_valid_o | output | 1 | Block code pulse (write mode) |
| code_blk_o | output | 2 | Block number of `code_o` |
| code_o | output | 24 | Generated block code |
| chk_done_o | output | 4 | Per-block: check result is present |
| stat_o | output | 8 | Per-block 2-bit status, block k at [2k+1:2k] |
| loc_o | output | 48 | Per-block 12-bit error location, block k at [12k+11:12k] |

## Verification
Every result comes through a single register stage. A block code appears one cycle after the clock edge that takes the block's final byte and is gone one cycle later. A block's status, location and done bit appear one cycle after its stored code is accepted, and the clear caused by an aligned start shows one cycle after the strobe. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, so each result is read exactly in the cycle it is due. Code pulses that show up at any other time are counted as stray.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

   typedef enum logic [1:0] {
      HECC_CLEAN    = 2'b00,
      HECC_FIXED    = 2'b01,
      HECC_CODE_ERR = 2'b10,
      HECC_FATAL    = 2'b11
   } hecc_stat_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_DATA  = 2'b01,
      PH_CHECK = 2'b10
   } hecc_phase_e;

endpackage

// File: rtl/hecc_accum.sv
// Running parity over one block; code_o is the code including the current byte.
module hecc_accum #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 9,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int HALF_W = IDX_W + BIT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                en_i,
   input  logic                last_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [DATA_W-1:0]   data_i,
   output logic [2*HALF_W-1:0] code_o
);

   logic [HALF_W-1:0] odd_q, even_q, odd_n, even_n;
   logic              byte_par;

   always_comb begin
      odd_n    = odd_q;
      even_n   = even_q;
      byte_par = ^data_i;
      if (en_i) begin
         for (int b = 0; b < DATA_W; b++) begin
            for (int k = 0; k < BIT_W; k++) begin
               if (((b >> k) & 1) == 1) odd_n[k]  = odd_n[k]  ^ data_i[b];
               else                     even_n[k] = even_n[k] ^ data_i[b];
            end
         end
         for (int k = 0; k < IDX_W; k++) begin
            if (idx_i[k]) odd_n[BIT_W+k]  = odd_n[BIT_W+k]  ^ byte_par;
            else          even_n[BIT_W+k] = even_n[BIT_W+k] ^ byte_par;
         end
      end
   end

   assign code_o = {even_n, odd_n};

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i || (en_i && last_i)) begin
         odd_q  <= '0;
         even_q <= '0;
      end else if (en_i) begin
         odd_q  <= odd_n;
         even_q <= even_n;
      end
   end

endmodule

// File: rtl/hecc_classify.sv
// Syndrome decode: clean, single data bit, single code bit, or uncorrectable.
module hecc_classify
   import hecc_pkg::*;
#(
   parameter int HALF_W = 12
) (
   input  logic [2*HALF_W-1:0] calc_i,
   input  logic [2*HALF_W-1:0] stored_i,
   output hecc_stat_e          stat_o,
   output logic [HALF_W-1:0]   loc_o
);

   logic [2*HALF_W-1:0] syn;
   logic                pairs_split;

   assign syn         = calc_i ^ stored_i;
   assign pairs_split = &(syn[HALF_W-1:0] ^ syn[2*HALF_W-1:HALF_W]);

   always_comb begin
      loc_o = '0;
      if (syn == '0) begin
         stat_o = HECC_CLEAN;
      end else if (pairs_split) begin
         stat_o = HECC_FIXED;
         loc_o  = syn[HALF_W-1:0];
      end else if ($onehot(syn)) begin
         stat_o = HECC_CODE_ERR;
      end else begin
         stat_o = HECC_FATAL;
      end
   end

endmodule

// File: rtl/hecc_seq.sv
// Page phase, byte/block counters and stored-code order.
module hecc_seq
   import hecc_pkg::*;
#(
   parameter int BLOCKS = 4,
   parameter int IDX_W  = 9,
   localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] start_ofs_i,
   input  logic             wr_mode_i,
   input  logic             din_valid_i,
   input  logic             chk_valid_i,
   output logic             page_start_o,
   output logic             acc_en_o,
   output logic             acc_last_o,
   output logic [IDX_W-1:0] byte_idx_o,
   output logic [BLK_W-1:0] blk_idx_o,
   output logic             wr_mode_o,
   output logic             chk_take_o,
   output logic [BLK_W-1:0] chk_idx_o
);

   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS - 1);

   hecc_phase_e      phase_q;
   logic             mode_q;
   logic [IDX_W-1:0] byte_q;
   logic [BLK_W-1:0] blk_q, chk_q;

   assign page_start_o = start_i && (start_ofs_i == '0);
   assign acc_en_o     = (phase_q == PH_DATA) && din_valid_i && !page_start_o;
   assign acc_last_o   = acc_en_o && (byte_q == '1);
   assign chk_take_o   = (phase_q == PH_CHECK) && chk_valid_i && !page_start_o;
   assign byte_idx_o   = byte_q;
   assign blk_idx_o    = blk_q;
   assign chk_idx_o    = chk_q;
   assign wr_mode_o    = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         mode_q  <= 1'b0;
         byte_q  <= '0;
         blk_q   <= '0;
         chk_q   <= '0;
      end else if (page_start_o) begin
         phase_q <= PH_DATA;
         mode_q  <= wr_mode_i;
         byte_q  <= '0;
         blk_q   <= '0;
         chk_q   <= '0;
      end else begin
         if (acc_en_o) begin
            byte_q <= byte_q + 1'b1;
            if (acc_last_o) begin
               blk_q <= blk_q + 1'b1;
               if (blk_q == LAST_BLK) phase_q <= mode_q ? PH_IDLE : PH_CHECK;
            end
         end
         if (chk_take_o) begin
            chk_q <= chk_q + 1'b1;
            if (chk_q == LAST_BLK) phase_q <= PH_IDLE;
         end
      end
   end

endmodule

// File: rtl/hecc_page_engine.sv
module hecc_page_engine
   import hecc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BLOCK_BYTES = 512,
   parameter int BLOCKS      = 4,
   localparam int IDX_W  = $clog2(BLOCK_BYTES),
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int HALF_W = IDX_W + BIT_W,
   localparam int CODE_W = 2 * HALF_W,
   localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [IDX_W-1:0]         start_ofs_i,
   input  logic                     wr_mode_i,
   input  logic                     din_valid_i,
   input  logic [DATA_W-1:0]        din_i,
   input  logic                     chk_valid_i,
   input  logic [CODE_W-1:0]        chk_code_i,
   output logic                     code_valid_o,
   output logic [BLK_W-1:0]         code_blk_o,
   output logic [CODE_W-1:0]        code_o,
   output logic [BLOCKS-1:0]        chk_done_o,
   output logic [2*BLOCKS-1:0]      stat_o,
   output logic [HALF_W*BLOCKS-1:0] loc_o
);

   if ((1 << IDX_W) != BLOCK_BYTES) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two");
   end
   if ((1 << BIT_W) != DATA_W || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (BLOCKS < 1 || BLOCKS > 16) begin : g_bad_blocks
      $error("BLOCKS must lie in 1..16");
   end

   logic              page_start, acc_en, acc_last, wr_mode, chk_take;
   logic [IDX_W-1:0]  byte_idx;
   logic [BLK_W-1:0]  blk_idx, chk_idx;
   logic [CODE_W-1:0] code_nxt;
   hecc_stat_e        cls_stat;
   logic [HALF_W-1:0] cls_loc;

   logic [CODE_W-1:0] comp_q [BLOCKS];
   hecc_stat_e        stat_q [BLOCKS];
   logic [HALF_W-1:0] loc_q  [BLOCKS];
   logic [BLOCKS-1:0] done_q;
   logic              cv_q;
   logic [BLK_W-1:0]  cblk_q;
   logic [CODE_W-1:0] code_q;

   hecc_seq #(.BLOCKS(BLOCKS), .IDX_W(IDX_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_ofs_i  (start_ofs_i),
      .wr_mode_i    (wr_mode_i),
      .din_valid_i  (din_valid_i),
      .chk_valid_i  (chk_valid_i),
      .page_start_o (page_start),
      .acc_en_o     (acc_en),
      .acc_last_o   (acc_last),
      .byte_idx_o   (byte_idx),
      .blk_idx_o    (blk_idx),
      .wr_mode_o    (wr_mode),
      .chk_take_o   (chk_take),
      .chk_idx_o    (chk_idx)
   );

   hecc_accum #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (page_start),
      .en_i   (acc_en),
      .last_i (acc_last),
      .idx_i  (byte_idx),
      .data_i (din_i),
      .code_o (code_nxt)
   );

   hecc_classify #(.HALF_W(HALF_W)) u_cls (
      .calc_i   (comp_q[chk_idx]),
      .stored_i (chk_code_i),
      .stat_o   (cls_stat),
      .loc_o    (cls_loc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cv_q   <= 1'b0;
         cblk_q <= '0;
         code_q <= '0;
      end else begin
         cv_q <= acc_last && wr_mode;
         if (acc_last) begin
            cblk_q <= blk_idx;
            code_q <= code_nxt;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || page_start) begin
         done_q <= '0;
         for (int k = 0; k < BLOCKS; k++) begin
            comp_q[k] <= '0;
            stat_q[k] <= HECC_CLEAN;
            loc_q[k]  <= '0;
         end
      end else begin
         if (acc_last && !wr_mode) comp_q[blk_idx] <= code_nxt;
         if (chk_take) begin
            stat_q[chk_idx] <= cls_stat;
            loc_q[chk_idx]  <= cls_loc;
            done_q[chk_idx] <= 1'b1;
         end
      end
   end

   assign code_valid_o = cv_q;
   assign code_blk_o   = cblk_q;
   assign code_o       = code_q;
   assign chk_done_o   = done_q;

   for (genvar k = 0; k < BLOCKS; k++) begin : g_flat
      assign stat_o[2*k +: 2]         = stat_q[k];
      assign loc_o[HALF_W*k +: HALF_W] = loc_q[k];
   end

endmodule

// File: rtl/hecc_page_engine_chk.sv
module hecc_page_engine_chk #(
   parameter int BLOCKS = 4,
   parameter int IDX_W  = 9,
   parameter int HALF_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic [IDX_W-1:0]         start_ofs_i,
   input logic                     din_valid_i,
   input logic                     code_valid_o,
   input logic [BLOCKS-1:0]        chk_done_o,
   input logic [2*BLOCKS-1:0]      stat_o,
   input logic [HALF_W*BLOCKS-1:0] loc_o
);

   logic aligned_start;
   assign aligned_start = start_i && (start_ofs_i == '0);

   // R2: a code pulse lasts one cycle
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |=> !code_valid_o);

   // R5: a code pulse always follows an accepted byte
   a_r5_code_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |-> $past(din_valid_i));

   // R10: aligned start wipes all results
   a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_start |=> (chk_done_o == '0 && stat_o == '0 && loc_o == '0));

   // R6: done bits never drop without an aligned start
   a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned_start |=> ((chk_done_o & $past(chk_done_o)) == $past(chk_done_o)));

   for (genvar k = 0; k < BLOCKS; k++) begin : g_blk
      // R7: a location is reported only for a corrected block
      a_r7_loc_only_fixed: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_o[2*k +: 2] != 2'b01) |-> (loc_o[HALF_W*k +: HALF_W] == '0));
      // R9: no status without a completed check
      a_r9_stat_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
         !chk_done_o[k] |-> (stat_o[2*k +: 2] == 2'b00));
   end

endmodule

bind hecc_page_engine hecc_page_engine_chk #(
   .BLOCKS (BLOCKS),
   .IDX_W  (IDX_W),
   .HALF_W (HALF_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .start_ofs_i  (start_ofs_i),
   .din_valid_i  (din_valid_i),
   .code_valid_o (code_valid_o),
   .chk_done_o   (chk_done_o),
   .stat_o       (stat_o),
   .loc_o        (loc_o)
);

// File: tb/hecc_page_engine_test.sv
`timescale 1ns/1ps
module hecc_page_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [8:0]  start_ofs_i = '0;
   logic        wr_mode_i = 1'b0;
   logic        din_valid_i = 1'b0;
   logic [7:0]  din_i = '0;
   logic        chk_valid_i = 1'b0;
   logic [23:0] chk_code_i = '0;
   logic        code_valid_o;
   logic [1:0]  code_blk_o;
   logic [23:0] code_o;
   logic [3:0]  chk_done_o;
   logic [7:0]  stat_o;
   logic [47:0] loc_o;

   int nvec = 0;
   int nerr = 0;
   int stray = 0;
   logic [31:0] seed = 32'h1234_5678;
   logic [7:0]  page [0:2047];
   logic [23:0] exp_code [0:3];

   always #2 clk = ~clk;

   hecc_page_engine uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ofs_i(start_ofs_i),
      .wr_mode_i(wr_mode_i), .din_valid_i(din_valid_i), .din_i(din_i),
      .chk_valid_i(chk_valid_i), .chk_code_i(chk_code_i),
      .code_valid_o(code_valid_o), .code_blk_o(code_blk_o), .code_o(code_o),
      .chk_done_o(chk_done_o), .stat_o(stat_o), .loc_o(loc_o)
   );

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ref_code(input int base);
      logic [8:0] lo, le;
      logic [2:0] co, ce;
      lo = '0; le = '0; co = '0; ce = '0;
      for (int i = 0; i < 512; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (page[base+i][b]) begin
               for (int k = 0; k < 9; k++) begin
                  if (i[k]) lo[k] = ~lo[k]; else le[k] = ~le[k];
               end
               for (int k = 0; k < 3; k++) begin
                  if (b[k]) co[k] = ~co[k]; else ce[k] = ~ce[k];
               end
            end
         end
      end
      return {le, ce, lo, co};
   endfunction

   task automatic fill_random();
      for (int i = 0; i < 2048; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         page[i] = seed[23:16];
      end
   endtask

   task automatic start_page(input logic [8:0] ofs, input logic wr);
      start_i = 1'b1; start_ofs_i = ofs; wr_mode_i = wr;
      cyc();
      start_i = 1'b0; start_ofs_i = '0;
   endtask

   task automatic stream_page(input bit expect_codes, input bit gaps);
      stray = 0;
      for (int b = 0; b < 4; b++) begin
         for (int i = 0; i < 512; i++) begin
            if (gaps && (i % 101) == 7) begin
               din_valid_i = 1'b0; din_i = 8'hA5;
               cyc();
               if (code_valid_o) stray++;
            end
            din_valid_i = 1'b1; din_i = page[b*512+i];
            cyc();
            if (i == 511) begin
               if (expect_codes) begin
                  chk("R2 pulse at block end", code_valid_o, 1);
                  chk("R2 block number", code_blk_o, b);
                  chk("R3 block code", code_o, exp_code[b]);
               end else begin
                  chk("R11 no code pulse in read", code_valid_o, 0);
               end
            end else if (code_valid_o) begin
               stray++;
            end
         end
      end
      din_valid_i = 1'b0;
      cyc();
      chk("R2 pulse lasts one cycle", code_valid_o, 0);
      chk("R2 no stray pulses", stray, 0);
   endtask

   task automatic t_reset();
      chk("R1 code_valid after reset", code_valid_o, 0);
      chk("R1 status after reset", stat_o, 0);
      chk("R1 location after reset", loc_o[31:0], 0);
      chk("R1 done after reset", chk_done_o, 0);
   endtask

   task automatic t_write_random();
      fill_random();
      for (int b = 0; b < 4; b++) exp_code[b] = ref_code(b*512);
      start_page(9'd0, 1'b1);
      stream_page(1'b1, 1'b1);
      // R5: bytes past the fourth block are ignored
      stray = 0;
      for (int i = 0; i < 512; i++) begin
         din_valid_i = 1'b1; din_i = page[i];
         cyc();
         if (code_valid_o) stray++;
      end
      din_valid_i = 1'b0; cyc();
      chk("R5 overrun bytes ignored", stray, 0);
      // R11: stored codes ignored in write mode
      chk_valid_i = 1'b1; chk_code_i = 24'h00FFFF;
      cyc(); cyc();
      chk_valid_i = 1'b0;
      cyc();
      chk("R11 chk ignored in write", chk_done_o, 0);
      chk("R11 status unchanged in write", stat_o, 0);
   endtask

   task automatic t_write_single_bit();
      for (int i = 0; i < 2048; i++) page[i] = 8'h00;
      page[300] = 8'h01;
      exp_code[0] = {~9'd300, 3'b111, 9'd300, 3'b000};
      chk("R3 reference for lone bit", ref_code(0), exp_code[0]);
      for (int b = 1; b < 4; b++) exp_code[b] = 24'h0;
      start_page(9'd0, 1'b1);
      stream_page(1'b1, 1'b0);
   endtask

   task automatic t_unaligned();
      fill_random();
      start_page(9'h040, 1'b1);
      stray = 0;
      for (int i = 0; i < 512; i++) begin
         din_valid_i = 1'b1; din_i = page[i];
         cyc();
         if (code_valid_o) stray++;
      end
      din_valid_i = 1'b0; cyc();
      chk("R4 misaligned start ignored", stray, 0);
   endtask

   task automatic t_read();
      logic [23:0] stored [0:3];
      fill_random();
      for (int b = 0; b < 4; b++) stored[b] = ref_code(b*512);
      stored[2] = stored[2] ^ 24'h000400;
      page[512+77]  = page[512+77]  ^ 8'h20;
      page[1536+10] = page[1536+10] ^ 8'h03;
      start_page(9'd0, 1'b0);
      stream_page(1'b0, 1'b1);
      chk("R6 nothing done before codes", chk_done_o, 0);
      for (int b = 0; b < 4; b++) begin
         chk_valid_i = 1'b1; chk_code_i = stored[b];
         cyc();
         chk_valid_i = 1'b0;
         chk("R12 done in block order", chk_done_o, (1 << (b+1)) - 1);
         case (b)
            0: begin
               chk("R6 clean status", stat_o[1:0], 2'b00);
               chk("R6 clean location", loc_o[11:0], 0);
            end
            1: begin
               chk("R7 corrected status", stat_o[3:2], 2'b01);
               chk("R7 location byte 77 bit 5", loc_o[23:12], 12'd621);
            end
            2: begin
               chk("R8 stored code damage", stat_o[5:4], 2'b10);
               chk("R8 location zero", loc_o[35:24], 0);
            end
            default: begin
               chk("R9 uncorrectable status", stat_o[7:6], 2'b11);
               chk("R9 location zero", loc_o[47:36], 0);
            end
         endcase
      end
      chk_valid_i = 1'b1; chk_code_i = 24'hFFFFFF;
      cyc();
      chk_valid_i = 1'b0;
      cyc();
      chk("R12 extra code ignored", stat_o, 8'hE4);
      chk("R12 extra code keeps location", loc_o[23:12], 12'd621);
   endtask

   task automatic t_hold_and_restart();
      repeat (20) cyc();
      chk("R10 status held while idle", stat_o, 8'hE4);
      start_page(9'h001, 1'b0);
      chk("R10 misaligned start keeps results", chk_done_o, 4'hF);
      start_page(9'd0, 1'b0);
      chk("R10 done cleared on start", chk_done_o, 0);
      chk("R10 status cleared on start", stat_o, 0);
      chk("R10 location cleared on start", loc_o[31:0], 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL R0 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (4) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_write_random();
      t_write_single_bit();
      t_unaligned();
      t_read();
      t_hold_and_restart();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule